// File: doc/BRIEF.md
# Hash-Based Queue ID Distributor

This block turns a 64-bit flow hash into a 24-bit frame-queue ID, so that traffic can be spread over a power-of-two range of queues. Each request carries the hash and the three configuration words of the scheme that matched the frame: a mode word, a hash-command word and a queue-base word. The block shifts the hash right by the programmed amount and keeps 24 bits. It masks them to the queue range and ORs the result onto the base queue ID. For an enabled scheme it also returns the enqueue next-action code.

Requests enter and results leave on valid/ready streams. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. The two-stage pipeline moves only as a whole. `in_ready` is high whenever the output register is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the pipeline holds and `in_ready` is low. Every accepted request yields exactly one result, in order. A disabled scheme still yields a result, marked as a miss.

Top module: `qid_spreader`

## Requirements
- R1: With `out_ready` held high, a request presented in cycle N appears on the output in cycle N+2. One request is accepted per cycle with no gaps.
- R2: The hash-command word holds the queue count minus one in bits [23:0], the right-shift amount in bits [29:24] and the symmetric flag in bit 30. The output queue ID is `base[23:0] | ((hash >> shift)[23:0] & count_m1)`.
- R3: A shift amount of 0 uses the 24 least significant bits of the hash.
- R4: A hash-command word of zero gives an output queue ID equal to the base queue ID.
- R5: An enabled scheme (mode bit 31 set) gives next-action 0x00500002 and a clear miss flag.
- R6: A disabled scheme (mode bit 31 clear) still produces a result. Its miss flag is 1, its queue ID is 0 and its next-action is 0.
- R7: Hash-command bit 30 is returned unchanged on `out_sym`.
- R8: `out_cfg_err` is 1 when any of these holds: base bits [23:0] are zero, base bits [31:24] are non-zero, or count_m1+1 is not a power of two. It is 0 otherwise.
- R9: While `out_valid` is high and `out_ready` is low, all outputs hold their values and `in_ready` is low.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_hash | input | 64 | Flow hash |
| in_mode | input | 32 | Scheme mode word (bit 31 enable) |
| in_hcmd | input | 32 | Hash-command word |
| in_qbase | input | 32 | Base queue ID word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result can be consumed |
| out_qid | output | 24 | Frame-queue ID |
| out_action | output | 32 | Next-action code |
| out_nomatch | output | 1 | Scheme disabled, no queue chosen |
| out_sym | output | 1 | Symmetric-hash flag |
| out_cfg_err | output | 1 | Configuration error |

## Verification
On every cycle the assertions check three things. Stalled results stay frozen and no request is taken under a stall. An enabled result always carries the enqueue action. A miss result always carries zero queue ID and action. Only the bench scenarios can show the rest. That covers the arithmetic of the shift, mask and base combination across shift amounts, the two-cycle latency and gap-free throughput, and the error-flag cases. It also covers the ordering of results under an irregular ready pattern, which the scoreboard compares item by item.

// File: rtl/qid_pkg.sv
package qid_pkg;
  localparam int HASH_W    = 64;
  localparam int QID_W     = 24;
  localparam int WORD_W    = 32;
  localparam int SHIFT_LSB = 24;
  localparam int SHIFT_W   = 6;
  localparam int SYM_BIT   = 30;
  localparam int EN_BIT    = 31;
  localparam logic [WORD_W-1:0] ENQ_ACTION = 32'h0050_0002;

  typedef struct packed {
    logic [QID_W-1:0] slice;
    logic [QID_W-1:0] mask;
    logic [QID_W-1:0] base;
    logic             en;
    logic             sym;
    logic             err;
  } stage1_t;

  typedef struct packed {
    logic [QID_W-1:0]  qid;
    logic [WORD_W-1:0] action;
    logic              nomatch;
    logic              sym;
    logic              err;
  } stage2_t;
endpackage

// File: rtl/qid_slice.sv
module qid_slice #(
  parameter int HASH_W  = 64,
  parameter int QID_W   = 24,
  parameter int SHIFT_W = 6
) (
  input  logic [HASH_W-1:0]  hash,
  input  logic [SHIFT_W-1:0] shamt,
  output logic [QID_W-1:0]   slice
);
  localparam int STAGES = SHIFT_W;
  logic [HASH_W-1:0] lvl [STAGES+1];

  assign lvl[0] = hash;
  // Log-depth barrel shifter: one conditional stage per shift bit.
  for (genvar i = 0; i < STAGES; i++) begin : g_bar
    assign lvl[i+1] = shamt[i] ? (lvl[i] >> (1 << i)) : lvl[i];
  end
  assign slice = lvl[STAGES][QID_W-1:0];
endmodule

// File: rtl/qid_cfg_check.sv
module qid_cfg_check #(
  parameter int QID_W  = 24,
  parameter int WORD_W = 32
) (
  input  logic [QID_W-1:0]  count_m1,
  input  logic [WORD_W-1:0] base_word,
  output logic              err
);
  logic [QID_W:0] cnt;
  logic           not_pow2;
  logic           base_zero;
  logic           base_wide;

  assign cnt       = {1'b0, count_m1} + 1'b1;
  assign not_pow2  = |(cnt & {1'b0, count_m1});
  assign base_zero = (base_word[QID_W-1:0] == '0);
  assign base_wide = |base_word[WORD_W-1:QID_W];
  assign err       = not_pow2 | base_zero | base_wide;
endmodule

// File: rtl/qid_pipe_reg.sv
module qid_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else if (adv) begin
      q_valid <= d_valid;
      q       <= d;
    end
  end
endmodule

// File: rtl/qid_spreader.sv
module qid_spreader
  import qid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HASH_W-1:0] in_hash,
  input  logic [WORD_W-1:0] in_mode,
  input  logic [WORD_W-1:0] in_hcmd,
  input  logic [WORD_W-1:0] in_qbase,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [QID_W-1:0]  out_qid,
  output logic [WORD_W-1:0] out_action,
  output logic              out_nomatch,
  output logic              out_sym,
  output logic              out_cfg_err
);
  localparam int S1_W = $bits(stage1_t);
  localparam int S2_W = $bits(stage2_t);

  logic    adv;
  stage1_t s1_d, s1_q;
  stage2_t s2_d, s2_q;
  logic    s1_v;
  logic [QID_W-1:0] slice;
  logic    err;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  qid_slice #(.HASH_W(HASH_W), .QID_W(QID_W), .SHIFT_W(SHIFT_W)) u_slice (
    .hash  (in_hash),
    .shamt (in_hcmd[SHIFT_LSB +: SHIFT_W]),
    .slice (slice)
  );

  qid_cfg_check #(.QID_W(QID_W), .WORD_W(WORD_W)) u_cfg (
    .count_m1  (in_hcmd[QID_W-1:0]),
    .base_word (in_qbase),
    .err       (err)
  );

  always_comb begin
    s1_d.slice = slice;
    s1_d.mask  = in_hcmd[QID_W-1:0];
    s1_d.base  = in_qbase[QID_W-1:0];
    s1_d.en    = in_mode[EN_BIT];
    s1_d.sym   = in_hcmd[SYM_BIT];
    s1_d.err   = err;
  end

  qid_pipe_reg #(.W(S1_W)) u_s1 (
    .clk (clk), .rst_n (rst_n), .adv (adv),
    .d_valid (in_valid), .d (s1_d),
    .q_valid (s1_v), .q (s1_q)
  );

  always_comb begin
    s2_d.qid     = s1_q.en ? (s1_q.base | (s1_q.slice & s1_q.mask)) : '0;
    s2_d.action  = s1_q.en ? ENQ_ACTION : '0;
    s2_d.nomatch = !s1_q.en;
    s2_d.sym     = s1_q.sym;
    s2_d.err     = s1_q.err;
  end

  qid_pipe_reg #(.W(S2_W)) u_s2 (
    .clk (clk), .rst_n (rst_n), .adv (adv),
    .d_valid (s1_v), .d (s2_d),
    .q_valid (out_valid), .q (s2_q)
  );

  assign out_qid     = s2_q.qid;
  assign out_action  = s2_q.action;
  assign out_nomatch = s2_q.nomatch;
  assign out_sym     = s2_q.sym;
  assign out_cfg_err = s2_q.err;
endmodule

// File: rtl/qid_spreader_chk.sv
module qid_spreader_chk #(
  parameter logic [31:0] ENQ = 32'h0050_0002
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_qid,
  input logic [31:0] out_action,
  input logic        out_nomatch,
  input logic        out_sym,
  input logic        out_cfg_err
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_qid) && $stable(out_action)
      && $stable(out_nomatch) && $stable(out_sym) && $stable(out_cfg_err)));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_enq_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nomatch) |-> (out_action == ENQ));

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nomatch) |-> (out_qid == '0 && out_action == '0));

  assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind qid_spreader qid_spreader_chk #(.ENQ(qid_pkg::ENQ_ACTION)) u_chk (
  .clk (clk), .rst_n (rst_n), .in_ready (in_ready),
  .out_valid (out_valid), .out_ready (out_ready),
  .out_qid (out_qid), .out_action (out_action),
  .out_nomatch (out_nomatch), .out_sym (out_sym), .out_cfg_err (out_cfg_err)
);

// File: tb/tb_qid_spreader.sv
`timescale 1ns/1ps
module tb_qid_spreader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_hash = '0;
  logic [31:0] in_mode = '0, in_hcmd = '0, in_qbase = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_qid;
  logic [31:0] out_action;
  logic        out_nomatch, out_sym, out_cfg_err;

  always #10 clk = ~clk;

  qid_spreader dut (.*);

  typedef struct packed {
    logic [23:0] qid;
    logic [31:0] action;
    logic        nomatch;
    logic        sym;
    logic        err;
  } exp_t;

  exp_t   exp_q[$];
  string  tag_q[$];
  int     due_q[$];
  int     total = 0, bad = 0, cyc = 0;
  bit     lat_mode = 0;
  bit     ready_toggle = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [63:0] h, input logic [31:0] m,
                                 input logic [31:0] c, input logic [31:0] b);
    exp_t e;
    logic [63:0] sh;
    logic [24:0] cnt;
    sh = h >> c[29:24];
    cnt = {1'b0, c[23:0]} + 25'd1;
    e.qid     = m[31] ? (b[23:0] | (sh[23:0] & c[23:0])) : 24'h0;
    e.action  = m[31] ? 32'h0050_0002 : 32'h0;
    e.nomatch = !m[31];
    e.sym     = c[30];
    e.err     = (b[23:0] == 0) || (b[31:24] != 0) || ((cnt & {1'b0, c[23:0]}) != 0);
    return e;
  endfunction

  task automatic send(input logic [63:0] h, input logic [31:0] m, input logic [31:0] c,
                      input logic [31:0] b, input string tag, output int waits);
    @(negedge clk);
    in_valid = 1'b1; in_hash = h; in_mode = m; in_hcmd = c; in_qbase = b;
    waits = 0;
    while (!in_ready) begin @(negedge clk); waits++; end
    exp_q.push_back(model(h, m, c, b));
    tag_q.push_back(tag);
    due_q.push_back(cyc + 2);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Ready pattern driver: changes just after the edge.
  always @(posedge clk) begin
    if (ready_toggle) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= lfsr[0] | lfsr[2];
    end else begin
      out_ready <= 1'b1;
    end
  end

  // Monitor / scoreboard.
  logic        stalled = 0;
  logic [23:0] p_qid;
  logic [31:0] p_act;
  logic        p_nm, p_sym, p_err;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        check(out_valid && out_qid == p_qid && out_action == p_act && out_nomatch == p_nm
              && out_sym == p_sym && out_cfg_err == p_err, "R9 hold",
              {out_qid, out_action[7:0]}, {p_qid, p_act[7:0]});
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R9 in_ready", in_ready, 0);
      stalled = out_valid && !out_ready;
      p_qid = out_qid; p_act = out_action; p_nm = out_nomatch; p_sym = out_sym; p_err = out_cfg_err;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R1 unexpected output", out_qid, 0);
        end else begin
          exp_t e;
          string t;
          int d;
          e = exp_q.pop_front(); t = tag_q.pop_front(); d = due_q.pop_front();
          check(out_qid == e.qid, {t, " qid"}, out_qid, e.qid);
          check(out_action == e.action, {t, " action"}, out_action, e.action);
          check(out_nomatch == e.nomatch, {t, " nomatch"}, out_nomatch, e.nomatch);
          check(out_sym == e.sym, {t, " sym"}, out_sym, e.sym);
          check(out_cfg_err == e.err, {t, " cfg_err"}, out_cfg_err, e.err);
          if (lat_mode) check(cyc == d, "R1 latency", cyc, d);
        end
      end
    end
  end

  bit done = 0;
  task automatic finish_all();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_all();
  end

  localparam logic [31:0] EN = 32'h8000_0000;

  initial begin
    int w;
    int gaps;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10 after release", {out_valid, in_ready}, 2'b01);

    lat_mode = 1;
    // R3: shift 0, count 16 -> low nibble of hash
    send(64'h1234_5678_9ABC_DEF7, EN, 32'h0000_000F, 32'h0000_0100, "R3 low bits", w);
    idle(); repeat (4) @(negedge clk);
    // R2: shift 8, count 256
    send(64'hFFFF_0000_00AB_CD00, EN, 32'h0800_00FF, 32'h0000_1000, "R2 shift8", w);
    // R2: shift 40, full mask
    send(64'hA1B2_C3D4_E5F6_0718, EN, 32'h28FF_FFFF, 32'h0000_0001, "R2 shift40", w);
    // R2: shift 63
    send(64'h8000_0000_0000_0000, EN, 32'h3F00_0003, 32'h0000_0010, "R2 shift63", w);
    // R4: hash command zero
    send(64'hDEAD_BEEF_CAFE_F00D, EN, 32'h0, 32'h00AB_CDE0, "R4 no hash", w);
    // R6: disabled scheme
    send(64'hDEAD_BEEF_CAFE_F00D, 32'h0050_0002, 32'h0000_000F, 32'h0000_0100, "R6 disabled", w);
    // R7: symmetric flag
    send(64'h0000_0000_0000_00FF, EN, 32'h4000_0007, 32'h0000_0040, "R7 sym", w);
    // R8: base zero, base too wide, non-pow2 count, all-ones count
    send(64'h5, EN, 32'h0000_0003, 32'h0000_0000, "R8 base zero", w);
    send(64'h5, EN, 32'h0000_0003, 32'h0100_0004, "R8 base wide", w);
    send(64'h5, EN, 32'h0000_0005, 32'h0000_0008, "R8 count not pow2", w);
    send(64'h5, EN, 32'h00FF_FFFF, 32'h0000_0001, "R8 count all ones", w);
    // R5: enabled scheme with ordinary config
    send(64'h0000_0000_0012_3456, EN, 32'h0400_003F, 32'h0000_0200, "R5 enable", w);
    idle(); repeat (4) @(negedge clk);

    // R1: throughput, eight back-to-back requests with no wait
    gaps = 0;
    for (int i = 0; i < 8; i++) begin
      send(64'h0101_0101_0101_0101 * (i + 1), EN, 32'h0000_0007, 32'h0000_0008 * (i + 1),
           "R1 burst", w);
      gaps += w;
    end
    idle();
    check(gaps == 0, "R1 no gaps", gaps, 0);
    repeat (4) @(negedge clk);

    // R9: irregular back-pressure, ordering through scoreboard
    lat_mode = 0;
    ready_toggle = 1;
    for (int i = 0; i < 40; i++) begin
      send({32'h9E37_79B9 * (i + 3), 32'h7F4A_7C15 * (i + 1)}, (i % 5 == 0) ? 32'h0 : EN,
           {2'b00, 6'(i), 24'h00_000F}, 32'h0000_0010 * (i + 1), "R9 backpressure", w);
    end
    idle();
    ready_toggle = 0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R1 all results delivered", exp_q.size(), 0);
    finish_all();
  end
endmodule